// File: doc/BRIEF.md
# Asynchronous Strobe Host Bus Slave

This block lets a host processor that runs without a shared clock read and write a bank of thirty-two 16-bit registers. The host selects the block with an active-low select, chooses the direction with a read/write level and marks each transfer with an active-low strobe. All three control inputs pass through two-flop synchronizers into the system clock domain. Once a synchronized strobe is seen inside a selected cycle, the block stores the write data or latches the addressed register for the host to read. It then pulls the acknowledge low. It releases the acknowledge as soon as the synchronized strobe or select goes high again.

Pad drivers sit outside the block. The data bus comes out as a value and an output enable, and the acknowledge comes out as a pull-down enable, so the acknowledge pad is an open-drain pin that is only ever pulled low or released. Register 0 holds interrupt pending bits, which hardware events set and the host clears by writing ones. Register 1 holds the matching enable bits. The interrupt output is high while any pending bit is also enabled. Registers 2 to 31 are plain read/write storage.

Top module: `hbus_slave`

## Requirements
- R1: After reset is asserted (asynchronously), the acknowledge pull-down is off, the bus output enable is low and the interrupt is low, and every register reads back 0x0000.
- R2: In a write cycle (select low, read/write low), the acknowledge pull-down turns on on the third rising clock edge after the strobe falls. By then the data has been stored at the addressed register.
- R3: In a read cycle (read/write high), the bus output enable turns on on the third rising edge after the strobe falls. The acknowledge turns on one edge later, and the bus then carries the addressed register's value.
- R4: The bus output enable is high only in a read cycle, and it drops combinationally the moment the raw strobe or raw select goes high.
- R5: The acknowledge pull-down stays on while the strobe is low. It turns off on the third rising edge after the strobe rises, or combinationally the moment the select goes high. A new cycle is accepted only after the acknowledge has been released.
- R6: A strobe given while the select is high causes no acknowledge and changes no register.
- R7: Register 0 is the interrupt pending register. A high event input bit sets the matching bit on the next edge. A host write clears each bit written as 1 and leaves the rest. An event that arrives in the same cycle as a clear keeps its bit set.
- R8: Register 1 is the interrupt enable register. The interrupt output goes high on the first edge after an event arrives whose enable bit is set. It stays low for pending bits that are not enabled.
- R9: Registers 2 to 31 store written values independently. A write to one register leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hcs_ni | input | 1 | Host select, active low |
| hrw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| hstb_ni | input | 1 | Host transfer strobe, active low |
| haddr_i | input | 5 | Register address |
| hdata_i | input | 16 | Write data from the data pad |
| hdata_o | output | 16 | Read data toward the data pad |
| hdata_oe_o | output | 1 | Data pad output enable; low means high impedance |
| hack_pull_o | output | 1 | Acknowledge pad pull-down enable; low means released |
| evt_i | input | 16 | Interrupt event inputs, one per pending bit |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A cycle state machine stuck in its acknowledge state appears at the pins as an acknowledge that never releases, visible three edges after the strobe rises. A state machine that skips its read-drive step appears as the acknowledge arriving one edge early, or as stale data on the bus at the moment of acknowledge. A corrupt pending or enable bit shows on the interrupt pin one edge after the event that should have changed it, and also in the value read back from register 0 or 1 on the next host cycle. A storage register hit by a write meant for another address shows up in the next read of that register.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int ADDR_PEND = 0;
  localparam int ADDR_EN   = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDRV = 2'd1,
    ST_ACK  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbus_fsm.sv
module hbus_fsm
  import hbus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic stb_s_i,
  input  logic rw_s_i,
  output logic wr_en_o,
  output logic rd_load_o,
  output logic ack_o,
  output logic rd_drv_o
);
  cyc_state_e state_q, state_d;
  logic       rd_cyc_q, rd_cyc_d;
  logic       start, done;

  assign start = !cs_s_i && !stb_s_i;
  assign done  = cs_s_i || stb_s_i;

  always_comb begin
    state_d   = state_q;
    rd_cyc_d  = rd_cyc_q;
    wr_en_o   = 1'b0;
    rd_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        rd_cyc_d  = rw_s_i;
        wr_en_o   = !rw_s_i;
        rd_load_o = rw_s_i;
        state_d   = rw_s_i ? ST_RDRV : ST_ACK;
      end
      ST_RDRV: state_d = done ? ST_IDLE : ST_ACK;
      ST_ACK:  if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rd_cyc_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_cyc_q <= rd_cyc_d;
    end
  end

  assign ack_o    = (state_q == ST_ACK);
  assign rd_drv_o = rd_cyc_q && (state_q != ST_IDLE);
endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank
  import hbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rd_arr [DEPTH];
  logic [DW-1:0] pend_q, pend_d, en_q, rdata_q;
  logic          pend_hit, en_hit;

  assign pend_hit = wr_en_i && (addr_i == AW'(ADDR_PEND));
  assign en_hit   = wr_en_i && (addr_i == AW'(ADDR_EN));

  always_comb begin
    pend_d = pend_q & ~(pend_hit ? wdata_i : '0);
    pend_d = pend_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_hit) en_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == ADDR_PEND) begin : g_pend
      assign rd_arr[i] = pend_q;
    end else if (i == ADDR_EN) begin : g_en
      assign rd_arr[i] = en_q;
    end else begin : g_store
      logic [DW-1:0] val_q;
      logic          hit;
      assign hit = wr_en_i && (addr_i == AW'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  val_q <= '0;
        else if (hit) val_q <= wdata_i;
      end
      assign rd_arr[i] = val_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (rd_load_i) rdata_q <= rd_arr[addr_i];
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign irq_o   = |(pend_q & en_q);
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int DW          = 16,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hcs_ni,
  input  logic          hrw_i,
  input  logic          hstb_ni,
  input  logic [AW-1:0] haddr_i,
  input  logic [DW-1:0] hdata_i,
  output logic [DW-1:0] hdata_o,
  output logic          hdata_oe_o,
  output logic          hack_pull_o,
  input  logic [DW-1:0] evt_i,
  output logic          irq_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n;
  logic [2:0]    ctl_s;
  logic          cs_s, stb_s, rw_s;
  logic          wr_en, rd_load, ack_st, rd_drv;
  logic [DW-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  hbus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({hcs_ni, hstb_ni, hrw_i}),
    .q_o   (ctl_s)
  );
  assign {cs_s, stb_s, rw_s} = ctl_s;

  hbus_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cs_s_i   (cs_s),
    .stb_s_i  (stb_s),
    .rw_s_i   (rw_s),
    .wr_en_o  (wr_en),
    .rd_load_o(rd_load),
    .ack_o    (ack_st),
    .rd_drv_o (rd_drv)
  );

  hbus_regbank #(.DW(DW), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .rd_load_i(rd_load),
    .addr_i   (haddr_i),
    .wdata_i  (hdata_i),
    .evt_i    (evt_i),
    .rdata_o  (hdata_o),
    .en_o     (en_q),
    .irq_o    (irq_o)
  );

  assign hdata_oe_o  = rd_drv && !hcs_ni && !hstb_ni;
  assign hack_pull_o = ack_st && !hcs_ni;
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          hrw_i,
  input logic          rw_s,
  input logic          hdata_oe_o,
  input logic          hack_pull_o,
  input logic          ack_st,
  input logic          wr_en,
  input logic [AW-1:0] haddr_i,
  input logic [DW-1:0] evt_i,
  input logic [DW-1:0] en_q,
  input logic          irq_o
);
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    hdata_oe_o |-> hrw_i); // R4

  AST_READ_ACK_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(hack_pull_o) && rw_s) |-> hdata_oe_o); // R3

  AST_ACK_GAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(ack_st) |=> !ack_st); // R5

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((|(evt_i & en_q)) && !(wr_en && haddr_i == AW'(1))) |=> irq_o); // R8
endmodule

bind hbus_slave hbus_slave_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .hrw_i      (hrw_i),
  .rw_s       (rw_s),
  .hdata_oe_o (hdata_oe_o),
  .hack_pull_o(hack_pull_o),
  .ack_st     (ack_st),
  .wr_en      (wr_en),
  .haddr_i    (haddr_i),
  .evt_i      (evt_i),
  .en_q       (en_q),
  .irq_o      (irq_o)
);

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rw = 1'b0, stb_n = 1'b1;
  logic [4:0]  addr = '0;
  logic [15:0] din = '0, evt = '0;
  logic [15:0] hdata_o;
  logic        hdata_oe_o, hack_pull_o, irq_o;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  hbus_slave u_hbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .hcs_ni(cs_n), .hrw_i(rw), .hstb_ni(stb_n),
    .haddr_i(addr), .hdata_i(din), .hdata_o(hdata_o), .hdata_oe_o(hdata_oe_o),
    .hack_pull_o(hack_pull_o), .evt_i(evt), .irq_o(irq_o)
  );

  // {rw, addr, data, expected}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'd7,  16'h0000, 16'h0000},
    {1'b0, 5'd2,  16'hA5A5, 16'h0000},
    {1'b0, 5'd31, 16'h1234, 16'h0000},
    {1'b0, 5'd15, 16'hFFFF, 16'h0000},
    {1'b1, 5'd2,  16'h0000, 16'hA5A5},
    {1'b1, 5'd31, 16'h0000, 16'h1234},
    {1'b1, 5'd15, 16'h0000, 16'hFFFF},
    {1'b0, 5'd2,  16'h0F0F, 16'h0000},
    {1'b1, 5'd2,  16'h0000, 16'h0F0F},
    {1'b1, 5'd31, 16'h0000, 16'h1234},
    {1'b1, 5'd0,  16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic r, input logic [4:0] a, input logic [15:0] d,
                      output logic [15:0] q);
    int first = 0;
    q = '0;
    @(negedge clk); cs_n = 1'b0; rw = r; addr = a; din = d;
    @(negedge clk); stb_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (hack_pull_o && first == 0) begin
        first = k;
        q = hdata_o;
        if (r) check(hdata_oe_o, "R3", 32'(hdata_oe_o), 32'd1);
      end
    end
    if (r) check(first == 4, "R3", first, 32'd4);
    else   check(first == 3, "R2", first, 32'd3);
    stb_n = 1'b1;
    #1 check(!hdata_oe_o, "R4", 32'(hdata_oe_o), 32'd0);
    @(negedge clk); @(negedge clk);
    check(hack_pull_o, "R5", 32'(hack_pull_o), 32'd1);
    @(negedge clk);
    check(!hack_pull_o, "R5", 32'(hack_pull_o), 32'd0);
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] q;
    #1 check(!hack_pull_o && !hdata_oe_o && !irq_o, "R1",
             {hack_pull_o, hdata_oe_o, irq_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][37], VEC[i][36:32], VEC[i][31:16], q);
      if (VEC[i][37]) check(q == VEC[i][15:0], "R9/R1 read", q, VEC[i][15:0]);
    end

    // R6: strobe while deselected
    xfer(1'b0, 5'd9, 16'h1111, q);
    @(negedge clk); cs_n = 1'b1; rw = 1'b0; addr = 5'd9; din = 16'h2222;
    @(negedge clk); stb_n = 1'b0;
    begin
      bit seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (hack_pull_o || hdata_oe_o) seen = 1;
      end
      check(!seen, "R6", 32'(seen), 32'd0);
    end
    stb_n = 1'b1; repeat (4) @(negedge clk);
    xfer(1'b1, 5'd9, 16'h0, q);
    check(q == 16'h1111, "R6", q, 16'h1111);

    // R5: select rising releases acknowledge at once
    @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = 5'd4; din = 16'h4444;
    @(negedge clk); stb_n = 1'b0;
    repeat (4) @(negedge clk);
    check(hack_pull_o, "R2", 32'(hack_pull_o), 32'd1);
    cs_n = 1'b1;
    #1 check(!hack_pull_o, "R5", 32'(hack_pull_o), 32'd0);
    @(negedge clk); stb_n = 1'b1; repeat (4) @(negedge clk);
    xfer(1'b1, 5'd4, 16'h0, q);
    check(q == 16'h4444, "R2", q, 16'h4444);

    // R7/R8: pending and enable
    @(negedge clk); evt = 16'h0008;
    @(negedge clk); evt = 16'h0000;
    check(!irq_o, "R8", 32'(irq_o), 32'd0);
    xfer(1'b1, 5'd0, 16'h0, q);
    check(q == 16'h0008, "R7", q, 16'h0008);
    xfer(1'b0, 5'd1, 16'h0008, q);
    check(irq_o, "R8", 32'(irq_o), 32'd1);
    xfer(1'b0, 5'd0, 16'h0008, q);
    check(!irq_o, "R8", 32'(irq_o), 32'd0);
    xfer(1'b1, 5'd0, 16'h0, q);
    check(q == 16'h0000, "R7", q, 16'h0000);
    xfer(1'b0, 5'd1, 16'h0001, q);
    @(negedge clk); evt = 16'h0001;
    @(negedge clk); evt = 16'h0000;
    check(irq_o, "R8", 32'(irq_o), 32'd1);
    xfer(1'b0, 5'd0, 16'h0001, q);
    check(!irq_o, "R7", 32'(irq_o), 32'd0);
    // event during clear keeps its bit
    @(negedge clk); evt = 16'h0004;
    xfer(1'b0, 5'd0, 16'h0004, q);
    evt = 16'h0000;
    xfer(1'b1, 5'd0, 16'h0, q);
    check(q == 16'h0004, "R7", q, 16'h0004);

    // R1: reset mid-run clears registers
    @(negedge clk); rst_n = 1'b0;
    #1 check(!irq_o && !hack_pull_o, "R1", {irq_o, hack_pull_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    xfer(1'b1, 5'd2, 16'h0, q);
    check(q == 16'h0000, "R1", q, 16'h0000);
    xfer(1'b1, 5'd1, 16'h0, q);
    check(q == 16'h0000, "R1", q, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule